// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

This block moves 16-bit register pairs between a register file and a byte-wide memory. It keeps its own 16-bit stack pointer and runs one stack operation at a time. The operation code picks what to move: a general register pair, the accumulator together with the packed flags, the program counter for a call to a fixed vector, or the program counter for a return. One return variant also asks the core to turn interrupts back on.

An operation starts on a one-cycle start strobe. The block then drives the memory port itself, one byte per cycle. It signals the end with a single-cycle done pulse, and values popped from the stack show up on the result outputs in that same cycle. The memory must answer a read in the same cycle that the address is presented.

Top module: `stk_seq`

## Requirements
- R1: After reset, `sp_out` equals the parameter `SP_INIT`. `mem_we`, `done` and `ime_set` are 0, and `pair_out`, `acc_out`, `flags_out` and `pc_out` are 0.
- R2: A pair push (op 0) has one internal cycle, then two write cycles, then the done cycle. The pointer is decremented before each byte is written. The high byte of `pair_in` goes to SP-1 and the low byte to SP-2, and `sp_out` ends at SP-2. Done comes 4 cycles after start is accepted.
- R3: A pair pop (op 2) reads the low byte at SP and the high byte at SP+1, with no memory write. `pair_out` becomes {high, low} and `sp_out` ends at SP+2. Done comes 3 cycles after start is accepted.
- R4: An accumulator/flags push (op 1) writes `acc_in` first, as the high byte. It then writes a flag byte with Z (`flags_in[3]`) in bit 7, N (`flags_in[2]`) in bit 6, H (`flags_in[1]`) in bit 5 and C (`flags_in[0]`) in bit 4. Bits 3..0 of that byte are written as 0.
- R5: An accumulator/flags pop (op 3) loads `flags_out` from bits 7..4 of the first byte read and `acc_out` from the second byte. Bits 3..0 of the first byte have no effect.
- R6: A call to vector (op 4) pushes `pc_in` with the same timing and byte order as R2. In the done cycle, `pc_out` becomes `vec_sel` × 8.
- R7: A return (op 5) and a return-from-interrupt (op 6) pop `pc_out` with the timing of R3. `ime_set` pulses together with done only for op 6.
- R8: `start` is ignored while an operation is in progress. Op code 7 is ignored: there is no memory cycle, no done pulse and no pointer change.
- R9: The stack pointer wraps modulo 2^16 on both decrement and increment.
- R10: `done` is high for exactly one cycle per operation. `mem_we` is high only in the two write cycles of a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| op | input | 3 | Operation code |
| vec_sel | input | 3 | Vector index for a call |
| pair_in | input | 16 | Register pair to push |
| acc_in | input | 8 | Accumulator to push |
| flags_in | input | 4 | Flags {Z,N,H,C} to push |
| pc_in | input | 16 | Program counter to push on a call |
| mem_rdata | input | 8 | Read data, valid in the address cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp_out | output | 16 | Current stack pointer |
| pair_out | output | 16 | Popped register pair |
| acc_out | output | 8 | Popped accumulator |
| flags_out | output | 4 | Popped flags {Z,N,H,C} |
| pc_out | output | 16 | Loaded program counter |
| ime_set | output | 1 | Interrupt re-enable pulse |
| done | output | 1 | End-of-operation pulse |

## Verification
The properties assume three things about the inputs. The memory returns read data in the address cycle. `op` and the data inputs are stable in the cycle where start is accepted. Reset holds the block idle. The bench meets these by using a combinational-read memory model in the bench and by changing inputs only on falling edges. The one exception is the ignore test: it deliberately keeps start high and changes `op` during an operation, to show that the accepted code alone decides the sequence.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH_RP  = 3'd0,
    OP_PUSH_AF  = 3'd1,
    OP_POP_RP   = 3'd2,
    OP_POP_AF   = 3'd3,
    OP_CALL_VEC = 3'd4,
    OP_RET      = 3'd5,
    OP_RETI     = 3'd6,
    OP_NONE     = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_GAP  = 3'd1,
    PH_WHI  = 3'd2,
    PH_WLO  = 3'd3,
    PH_RLO  = 3'd4,
    PH_RHI  = 3'd5
  } stk_ph_e;

  function automatic logic op_is_push(stk_op_e o);
    return (o == OP_PUSH_RP) || (o == OP_PUSH_AF) || (o == OP_CALL_VEC);
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] op,
  output stk_ph_e    ph_q,
  output stk_ph_e    ph_d,
  output stk_op_e    op_q,
  output logic       accept
);

  stk_op_e op_in;
  assign op_in = stk_op_e'(op);

  always_comb begin
    ph_d   = ph_q;
    accept = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start && (op_in != OP_NONE)) begin
          accept = 1'b1;
          ph_d   = op_is_push(op_in) ? PH_GAP : PH_RLO;
        end
      end
      PH_GAP:  ph_d = PH_WHI;
      PH_WHI:  ph_d = PH_WLO;
      PH_WLO:  ph_d = PH_IDLE;
      PH_RLO:  ph_d = PH_RHI;
      PH_RHI:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      op_q <= OP_NONE;
    end else begin
      ph_q <= ph_d;
      if (accept) op_q <= op_in;
    end
  end

endmodule

// File: rtl/stk_sp_unit.sv
module stk_sp_unit
  import stk_pkg::*;
#(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] SP_INIT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_ph_e       ph_d,
  output logic [AW-1:0] sp
);

  logic dec, inc;
  assign dec = (ph_d == PH_GAP) || (ph_d == PH_WHI);
  assign inc = (ph_d == PH_RLO) || (ph_d == PH_RHI);

  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_INIT;
    else if (dec) sp <= sp - 1'b1;
    else if (inc) sp <= sp + 1'b1;
  end

endmodule

// File: rtl/stk_port.sv
module stk_port
  import stk_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_ph_e       ph_d,
  input  logic [AW-1:0] sp,
  input  logic [DW-1:0] wr_hi,
  input  logic [DW-1:0] wr_lo,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);

  logic bus_cyc;
  assign bus_cyc = (ph_d == PH_WHI) || (ph_d == PH_WLO) ||
                   (ph_d == PH_RLO) || (ph_d == PH_RHI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      mem_we <= (ph_d == PH_WHI) || (ph_d == PH_WLO);
      if (bus_cyc)         mem_addr  <= sp;
      if (ph_d == PH_WHI)  mem_wdata <= wr_hi;
      else if (ph_d == PH_WLO) mem_wdata <= wr_lo;
    end
  end

endmodule

// File: rtl/stk_result.sv
module stk_result
  import stk_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NFLAG     = 4,
  parameter int VSEL_W    = 3,
  parameter int VEC_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_ph_e           ph_q,
  input  stk_op_e           op_q,
  input  logic              accept,
  input  logic [2:0]        op_in,
  input  logic [2*DW-1:0]   pair_in,
  input  logic [DW-1:0]     acc_in,
  input  logic [NFLAG-1:0]  flags_in,
  input  logic [2*DW-1:0]   pc_in,
  input  logic [VSEL_W-1:0] vec_sel,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     wr_hi,
  output logic [DW-1:0]     wr_lo,
  output logic [2*DW-1:0]   pair_out,
  output logic [DW-1:0]     acc_out,
  output logic [NFLAG-1:0]  flags_out,
  output logic [2*DW-1:0]   pc_out,
  output logic              ime_set,
  output logic              done
);

  localparam int PW = 2 * DW;

  logic [DW-1:0]     lo_cap;
  logic [VSEL_W-1:0] vec_q;
  logic [PW-1:0]     vec_word;
  logic [PW-1:0]     pop_word;
  stk_op_e           op_new;

  assign op_new   = stk_op_e'(op_in);
  assign vec_word = {{(PW-VSEL_W){1'b0}}, vec_q} << VEC_SHIFT;
  assign pop_word = {mem_rdata, lo_cap};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_hi  <= '0;
      wr_lo  <= '0;
      vec_q  <= '0;
    end else if (accept) begin
      vec_q <= vec_sel;
      if (op_new == OP_PUSH_AF) begin
        wr_hi <= acc_in;
        wr_lo <= {flags_in, {(DW-NFLAG){1'b0}}};
      end else if (op_new == OP_CALL_VEC) begin
        {wr_hi, wr_lo} <= pc_in;
      end else begin
        {wr_hi, wr_lo} <= pair_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cap    <= '0;
      pair_out  <= '0;
      acc_out   <= '0;
      flags_out <= '0;
      pc_out    <= '0;
      ime_set   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done    <= (ph_q == PH_WLO) || (ph_q == PH_RHI);
      ime_set <= (ph_q == PH_RHI) && (op_q == OP_RETI);
      if (ph_q == PH_RLO) lo_cap <= mem_rdata;
      if (ph_q == PH_WLO && op_q == OP_CALL_VEC) pc_out <= vec_word;
      if (ph_q == PH_RHI) begin
        case (op_q)
          OP_POP_RP: pair_out <= pop_word;
          OP_POP_AF: begin
            acc_out   <= mem_rdata;
            flags_out <= lo_cap[DW-1 -: NFLAG];
          end
          OP_RET, OP_RETI: pc_out <= pop_word;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int                DW        = 8,
  parameter int                NFLAG     = 4,
  parameter int                VSEL_W    = 3,
  parameter int                VEC_SHIFT = 3,
  parameter logic [2*DW-1:0]   SP_INIT   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [VSEL_W-1:0] vec_sel,
  input  logic [2*DW-1:0]   pair_in,
  input  logic [DW-1:0]     acc_in,
  input  logic [NFLAG-1:0]  flags_in,
  input  logic [2*DW-1:0]   pc_in,
  input  logic [DW-1:0]     mem_rdata,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic [2*DW-1:0]   sp_out,
  output logic [2*DW-1:0]   pair_out,
  output logic [DW-1:0]     acc_out,
  output logic [NFLAG-1:0]  flags_out,
  output logic [2*DW-1:0]   pc_out,
  output logic              ime_set,
  output logic              done
);

  localparam int AW = 2 * DW;

  stk_ph_e       ph_q, ph_d;
  stk_op_e       op_q;
  logic          accept;
  logic          busy;
  logic [DW-1:0] wr_hi, wr_lo;

  assign busy = (ph_q != PH_IDLE);

  stk_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .ph_q   (ph_q),
    .ph_d   (ph_d),
    .op_q   (op_q),
    .accept (accept)
  );

  stk_sp_unit #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk  (clk),
    .rst  (rst),
    .ph_d (ph_d),
    .sp   (sp_out)
  );

  stk_port #(.DW(DW), .AW(AW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .ph_d      (ph_d),
    .sp        (sp_out),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  stk_result #(.DW(DW), .NFLAG(NFLAG), .VSEL_W(VSEL_W), .VEC_SHIFT(VEC_SHIFT)) u_res (
    .clk       (clk),
    .rst       (rst),
    .ph_q      (ph_q),
    .op_q      (op_q),
    .accept    (accept),
    .op_in     (op),
    .pair_in   (pair_in),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .pc_in     (pc_in),
    .vec_sel   (vec_sel),
    .mem_rdata (mem_rdata),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .pair_out  (pair_out),
    .acc_out   (acc_out),
    .flags_out (flags_out),
    .pc_out    (pc_out),
    .ime_set   (ime_set),
    .done      (done)
  );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2:0]    op,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp,
  input logic          done,
  input logic          ime_set
);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_second_write_below_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> (mem_we && (mem_addr == AW'($past(mem_addr) - 1'b1))));

  assert_done_after_writes_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> done);

  assert_ime_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    ime_set |-> done);

  assert_sp_unit_step_R9: assert property (@(posedge clk) disable iff (rst)
    (sp != $past(sp)) |-> ((sp == AW'($past(sp) + 1'b1)) || (sp == AW'($past(sp) - 1'b1))));

  assert_null_op_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op == 3'd7)) |=> !busy);

endmodule

bind stk_seq stk_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .op       (op),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp       (sp_out),
  .done     (done),
  .ime_set  (ime_set)
);

// File: tb/stk_seq_tb.sv
module stk_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  vec_sel = 3'd0;
  logic [15:0] pair_in = '0;
  logic [7:0]  acc_in = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, sp_out, pair_out, pc_out;
  logic [7:0]  mem_wdata, acc_out;
  logic [3:0]  flags_out;
  logic        mem_we, ime_set, done;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq #(.SP_INIT(16'h0004)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .vec_sel(vec_sel),
    .pair_in(pair_in), .acc_in(acc_in), .flags_in(flags_in), .pc_in(pc_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .sp_out(sp_out), .pair_out(pair_out), .acc_out(acc_out),
    .flags_out(flags_out), .pc_out(pc_out), .ime_set(ime_set), .done(done)
  );

  // bench memory: 256 bytes, aliased on the low address byte
  logic [7:0]  bmem [256];
  logic [15:0] wla  [256];
  logic [7:0]  wld  [256];
  int wn = 0;

  assign mem_rdata = bmem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[7:0]] <= mem_wdata;
      wla[wn % 256] <= mem_addr;
      wld[wn % 256] <= mem_wdata;
      wn <= wn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int          r_cyc, r_nwr, r_w0;
  logic        r_ime;
  logic [15:0] sp_m = 16'h0004;

  task automatic run(input logic [2:0] o, input logic [2:0] vs, input bit hold);
    r_w0 = wn;
    @(negedge clk);
    op = o; vec_sel = vs; start = 1'b1;
    r_cyc = 0; r_ime = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      r_cyc++;
      if (hold) op = 3'd2; else start = 1'b0;
      if (done) begin r_ime = ime_set; break; end
    end
    start = 1'b0;
    r_nwr = wn - r_w0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done width", {31'd0, done}, 32'd0);
  endtask

  task automatic check_push(input logic [7:0] hi, input logic [7:0] lo, input string req);
    chk(r_cyc == 4, {req, " cycles"}, r_cyc, 4);
    chk(r_nwr == 2, {req, " write count R10"}, r_nwr, 2);
    chk(wla[r_w0 % 256] == 16'(sp_m - 16'd1), {req, " hi addr"}, wla[r_w0 % 256], 16'(sp_m - 16'd1));
    chk(wld[r_w0 % 256] == hi, {req, " hi data"}, wld[r_w0 % 256], hi);
    chk(wla[(r_w0+1) % 256] == 16'(sp_m - 16'd2), {req, " lo addr"}, wla[(r_w0+1) % 256], 16'(sp_m - 16'd2));
    chk(wld[(r_w0+1) % 256] == lo, {req, " lo data"}, wld[(r_w0+1) % 256], lo);
    sp_m = sp_m - 16'd2;
    chk(sp_out == sp_m, {req, " sp"}, sp_out, sp_m);
  endtask

  task automatic check_pop(input string req);
    chk(r_cyc == 3, {req, " cycles"}, r_cyc, 3);
    chk(r_nwr == 0, {req, " no write R10"}, r_nwr, 0);
    sp_m = sp_m + 16'd2;
    chk(sp_out == sp_m, {req, " sp"}, sp_out, sp_m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sp_out == 16'h0004, "R1 sp", sp_out, 16'h0004);
    chk(!mem_we && !done && !ime_set, "R1 strobes", {mem_we, done, ime_set}, 0);
    chk(pair_out == 0 && acc_out == 0 && flags_out == 0 && pc_out == 0, "R1 outputs",
        {pair_out, pc_out}, 0);

    // R2 / R3 pair round trips
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = 16'(16'h1357 * k) ^ 16'hA5C3;
      pair_in = v;
      run(3'd0, 3'd0, 1'b0);
      check_push(v[15:8], v[7:0], "R2 push pair");
      pair_in = 16'h0000;
      run(3'd2, 3'd0, 1'b0);
      check_pop("R3 pop pair");
      chk(pair_out == v, "R3 pair value", pair_out, v);
    end

    // R4 / R5 all flag combinations
    for (int f = 0; f < 16; f++) begin
      acc_in = 8'(8'h40 + f * 3); flags_in = 4'(f);
      run(3'd1, 3'd0, 1'b0);
      check_push(8'(8'h40 + f * 3), {4'(f), 4'b0000}, "R4 push af");
      acc_in = 8'h00; flags_in = 4'h0;
      run(3'd3, 3'd0, 1'b0);
      check_pop("R5 pop af");
      chk(flags_out == 4'(f), "R5 flags", flags_out, f);
      chk(acc_out == 8'(8'h40 + f * 3), "R5 acc", acc_out, 8'(8'h40 + f * 3));
    end

    // R5 low nibble of flag byte ignored
    pair_in = 16'h9AB7;
    run(3'd0, 3'd0, 1'b0);
    check_push(8'h9A, 8'hB7, "R5 setup push");
    run(3'd3, 3'd0, 1'b0);
    check_pop("R5 pop af low nibble");
    chk(flags_out == 4'hB, "R5 low nibble ignored flags", flags_out, 4'hB);
    chk(acc_out == 8'h9A, "R5 low nibble ignored acc", acc_out, 8'h9A);

    // R6 / R7 call each vector then return
    for (int v = 0; v < 8; v++) begin
      logic [15:0] pcv;
      pcv = 16'(16'h1230 + v * 16'h0111);
      pc_in = pcv;
      run(3'd4, 3'(v), 1'b0);
      check_push(pcv[15:8], pcv[7:0], "R6 call");
      chk(pc_out == 16'(v * 8), "R6 vector", pc_out, 16'(v * 8));
      pc_in = 16'h0000;
      run((v % 2 == 0) ? 3'd5 : 3'd6, 3'd0, 1'b0);
      check_pop("R7 return");
      chk(pc_out == pcv, "R7 pc", pc_out, pcv);
      chk(r_ime == (v % 2 == 1), "R7 ime_set", {31'd0, r_ime}, (v % 2 == 1));
    end

    // R9 wrap below zero and back
    pair_in = 16'h1111; run(3'd0, 3'd0, 1'b0); check_push(8'h11, 8'h11, "R9 push a");
    pair_in = 16'h2222; run(3'd0, 3'd0, 1'b0); check_push(8'h22, 8'h22, "R9 push b");
    pair_in = 16'h3344; run(3'd0, 3'd0, 1'b0); check_push(8'h33, 8'h44, "R9 push wrap");
    chk(sp_out == 16'hFFFE, "R9 sp wrapped down", sp_out, 16'hFFFE);
    run(3'd2, 3'd0, 1'b0); check_pop("R9 pop wrap");
    chk(pair_out == 16'h3344, "R9 wrap value", pair_out, 16'h3344);
    chk(sp_out == 16'h0000, "R9 sp wrapped up", sp_out, 16'h0000);
    run(3'd2, 3'd0, 1'b0); check_pop("R9 pop b");
    chk(pair_out == 16'h2222, "R9 value b", pair_out, 16'h2222);
    run(3'd2, 3'd0, 1'b0); check_pop("R9 pop a");
    chk(pair_out == 16'h1111, "R9 value a", pair_out, 16'h1111);

    // R8 start held with another op during a push
    pair_in = 16'hC0DE;
    run(3'd0, 3'd0, 1'b1);
    check_push(8'hC0, 8'hDE, "R8 busy ignore");
    run(3'd2, 3'd0, 1'b0); check_pop("R8 restore");
    chk(pair_out == 16'hC0DE, "R8 value", pair_out, 16'hC0DE);

    // R8 null op code 7
    begin
      int w0;
      bit seen;
      w0 = wn; seen = 1'b0;
      @(negedge clk); op = 3'd7; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 5; i++) begin
        if (done) seen = 1'b1;
        @(negedge clk);
      end
      chk(!seen, "R8 null op done", {31'd0, seen}, 0);
      chk(wn == w0, "R8 null op writes", wn - w0, 0);
      chk(sp_out == sp_m, "R8 null op sp", sp_out, sp_m);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule